// File: doc/BRIEF.md
# Montgomery Modular Exponentiation Engine

This block raises a base to an exponent modulo an odd modulus, all numbers `W` bits wide. The running product is kept in Montgomery form with radix `r = 2^W`, so each step is a Montgomery product and the block never divides. A single small digit-serial Montgomery multiplier does all the work, one product at a time. An internal sequencer steps the exponent from its highest set bit down to bit 0. Every bit causes a squaring, and every 1 bit causes an extra multiply by the converted base.

The caller supplies two values computed elsewhere. The first is `r^2 mod n`. The second is the low digit of `n' = -n^-1 mod 2^W`. The block first builds `r mod n`, which is the Montgomery form of 1, by multiplying `r^2 mod n` with 1. It then moves the base into Montgomery form by multiplying it with `r^2 mod n`, runs the bit loop, and leaves Montgomery form with a last product by 1. With `CONV_BASE = 0` the caller supplies the base already in Montgomery form and the base conversion is skipped. This suits a fixed modulus whose converted values are kept in storage.

A start pulse latches all operands. A one-cycle `done_o` pulse marks the result, which is held until the next result.

Top module: `mexp_engine`

## Requirements
- R1: After reset `done_o` is 0 and `result_o` is 0.
- R2: For an odd modulus `n` and exponent `e`, the block returns `base^e mod n`, including `e = 17`. The returned value is always below `n` when `n > 1`.
- R3: An exponent of 0 returns `1 mod n`, which is 1 for `n > 1` and 0 for `n = 1`.
- R4: Any `W`-bit base is accepted, including bases at or above `n`, and is reduced correctly.
- R5: `done_o` is high for exactly one cycle per operation. `result_o` changes only in that cycle and holds its value afterwards.
- R6: `start_i` is ignored from the cycle after an accepted start up to and including the `done_o` cycle. A start inside that window neither changes the running result nor produces a further `done_o`.
- R7: With `CONV_BASE = 0`, `base_i` is taken as `x*r mod n`, and the block returns `x^e mod n`.
- R8: The exponent is scanned from its most significant set bit down to bit 0. A full-width exponent with its top bit set, and an exponent with only its top bit set, both give correct results.
- R9: `nprime_i` carries `n' mod 2^DIGIT_W`, where `n' = -n^-1 mod 2^W`. `r2_i` carries `2^(2W) mod n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; latches all operands when idle |
| base_i | input | W | Base (Montgomery form when CONV_BASE = 0) |
| exp_i | input | EXP_W | Exponent |
| mod_i | input | W | Odd modulus n |
| nprime_i | input | DIGIT_W | Low digit of -n^-1 mod 2^W |
| r2_i | input | W | 2^(2W) mod n |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | W | base^e mod n, held between operations |

## Verification
The case that needs care is a new start request arriving in the same cycle that the previous result is being delivered on `done_o`. The bench drives `start_i` high, with different operands, exactly in the `done_o` cycle. It then waits more than a full operation's length and judges two things: that no second `done_o` appears, and that `result_o` keeps the first result. A start issued in the middle of a run is checked the same way against the first operation's reference value. Results are compared with a plain modular power computed in the bench, for both base-conversion variants at once.

// File: rtl/mexp_pkg.sv
package mexp_pkg;

   typedef enum logic [2:0] {
      S_IDLE     = 3'd0,
      S_ONE      = 3'd1,
      S_TOMONT   = 3'd2,
      S_SQR      = 3'd3,
      S_MUL      = 3'd4,
      S_STEP     = 3'd5,
      S_FROMMONT = 3'd6,
      S_FIN      = 3'd7
   } mexp_state_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mexp_msb.sv
module mexp_msb #(
   parameter int unsigned EXP_W = 16,
   parameter int unsigned IW    = 4
) (
   input  logic [EXP_W-1:0] e_i,
   output logic [IW-1:0]    idx_o,
   output logic             nz_o
);

   always_comb begin
      idx_o = '0;
      for (int i = 0; i < int'(EXP_W); i++) begin
         if (e_i[i]) idx_o = IW'(i);
      end
   end

   assign nz_o = |e_i;

endmodule

// File: rtl/mexp_montmul.sv
module mexp_montmul #(
   parameter int unsigned W       = 16,
   parameter int unsigned DIGIT_W = 4
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               go_i,
   input  logic [W-1:0]       a_i,
   input  logic [W-1:0]       b_i,
   input  logic [W-1:0]       n_i,
   input  logic [DIGIT_W-1:0] np_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [W-1:0]       res_o
);

   localparam int unsigned STEPS = W / DIGIT_W;
   localparam int unsigned CW    = (STEPS > 1) ? $clog2(STEPS) : 1;
   localparam int unsigned TW    = W + DIGIT_W + 2;

   generate
      if (DIGIT_W == 0 || DIGIT_W > W) begin : g_bad_digit
         $error("DIGIT_W must lie in 1..W");
      end
      if ((W % DIGIT_W) != 0) begin : g_bad_split
         $error("W must be a multiple of DIGIT_W");
      end
   endgenerate

   logic [W-1:0]       a_sh;
   logic [W-1:0]       b_q;
   logic [TW-1:0]      t_q;
   logic [CW-1:0]      cnt_q;
   logic               busy_q;
   logic               done_q;
   logic [W-1:0]       res_q;

   logic [DIGIT_W-1:0] digit;
   logic [DIGIT_W-1:0] low_k;
   logic [DIGIT_W-1:0] q_k;
   logic [TW-1:0]      ab;
   logic [TW-1:0]      qn;
   logic [TW-1:0]      sum;
   logic [TW-1:0]      t_nx;
   logic [TW-1:0]      t_red;

   always_comb begin
      digit = a_sh[DIGIT_W-1:0];
      low_k = t_q[DIGIT_W-1:0] + DIGIT_W'(digit * b_q[DIGIT_W-1:0]);
      q_k   = DIGIT_W'(low_k * np_i);
      ab    = {{(TW-DIGIT_W){1'b0}}, digit} * {{(TW-W){1'b0}}, b_q};
      qn    = {{(TW-DIGIT_W){1'b0}}, q_k} * {{(TW-W){1'b0}}, n_i};
      sum   = t_q + ab + qn;
      t_nx  = sum >> DIGIT_W;
      t_red = (t_nx >= {{(TW-W){1'b0}}, n_i}) ? (t_nx - {{(TW-W){1'b0}}, n_i}) : t_nx;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         a_sh   <= '0;
         b_q    <= '0;
         t_q    <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= 1'b0;
         if (go_i && !busy_q) begin
            a_sh   <= a_i;
            b_q    <= b_i;
            t_q    <= '0;
            cnt_q  <= '0;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            a_sh  <= a_sh >> DIGIT_W;
            t_q   <= t_nx;
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CW'(STEPS - 1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= t_red[W-1:0];
            end
         end
      end
   end

   assign busy_o = busy_q;
   assign done_o = done_q;
   assign res_o  = res_q;

endmodule

// File: rtl/mexp_engine.sv
module mexp_engine
   import mexp_pkg::*;
#(
   parameter int unsigned W         = 16,
   parameter int unsigned DIGIT_W   = 4,
   parameter int unsigned EXP_W     = 16,
   parameter bit          CONV_BASE = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               start_i,
   input  logic [W-1:0]       base_i,
   input  logic [EXP_W-1:0]   exp_i,
   input  logic [W-1:0]       mod_i,
   input  logic [DIGIT_W-1:0] nprime_i,
   input  logic [W-1:0]       r2_i,
   output logic               done_o,
   output logic [W-1:0]       result_o
);

   localparam int unsigned IW = idx_width(EXP_W);

   generate
      if (EXP_W == 0) begin : g_bad_exp
         $error("EXP_W must be at least 1");
      end
   endgenerate

   mexp_state_t        st_q;
   mexp_state_t        after_one;
   mexp_state_t        loop_entry;
   logic               mm_go;
   logic               mm_busy;
   logic               mm_done;
   logic [W-1:0]       mm_res;
   logic [W-1:0]       op_a;
   logic [W-1:0]       op_b;

   logic [W-1:0]       acc_q;
   logic [W-1:0]       xm_q;
   logic [W-1:0]       mod_q;
   logic [W-1:0]       r2_q;
   logic [DIGIT_W-1:0] np_q;
   logic [EXP_W-1:0]   e_q;
   logic [IW-1:0]      idx_q;
   logic               e_nz_q;
   logic [W-1:0]       res_q;
   logic               done_q;

   logic [IW-1:0]      msb_idx;
   logic               msb_nz;

   localparam logic [W-1:0] ONE = W'(1);

   mexp_msb #(.EXP_W(EXP_W), .IW(IW)) msb_i (
      .e_i   (exp_i),
      .idx_o (msb_idx),
      .nz_o  (msb_nz)
   );

   mexp_montmul #(.W(W), .DIGIT_W(DIGIT_W)) mul_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .go_i   (mm_go),
      .a_i    (op_a),
      .b_i    (op_b),
      .n_i    (mod_q),
      .np_i   (np_q),
      .busy_o (mm_busy),
      .done_o (mm_done),
      .res_o  (mm_res)
   );

   assign loop_entry = e_nz_q ? S_SQR : S_FROMMONT;

   generate
      if (CONV_BASE) begin : g_conv
         assign after_one = S_TOMONT;
      end else begin : g_preconv
         assign after_one = loop_entry;
      end
   endgenerate

   always_comb begin
      unique case (st_q)
         S_ONE:      begin op_a = r2_q;  op_b = ONE;   end
         S_TOMONT:   begin op_a = xm_q;  op_b = r2_q;  end
         S_SQR:      begin op_a = acc_q; op_b = acc_q; end
         S_MUL:      begin op_a = acc_q; op_b = xm_q;  end
         S_FROMMONT: begin op_a = acc_q; op_b = ONE;   end
         default:    begin op_a = '0;    op_b = '0;    end
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= S_IDLE;
         mm_go  <= 1'b0;
         acc_q  <= '0;
         xm_q   <= '0;
         mod_q  <= '0;
         r2_q   <= '0;
         np_q   <= '0;
         e_q    <= '0;
         idx_q  <= '0;
         e_nz_q <= 1'b0;
         res_q  <= '0;
         done_q <= 1'b0;
      end else begin
         mm_go  <= 1'b0;
         done_q <= 1'b0;
         unique case (st_q)
            S_IDLE: begin
               if (start_i) begin
                  xm_q   <= base_i;
                  e_q    <= exp_i;
                  mod_q  <= mod_i;
                  np_q   <= nprime_i;
                  r2_q   <= r2_i;
                  idx_q  <= msb_idx;
                  e_nz_q <= msb_nz;
                  st_q   <= S_ONE;
                  mm_go  <= 1'b1;
               end
            end
            S_ONE: begin
               if (mm_done) begin
                  acc_q <= mm_res;
                  st_q  <= after_one;
                  mm_go <= 1'b1;
               end
            end
            S_TOMONT: begin
               if (mm_done) begin
                  xm_q  <= mm_res;
                  st_q  <= loop_entry;
                  mm_go <= 1'b1;
               end
            end
            S_SQR: begin
               if (mm_done) begin
                  acc_q <= mm_res;
                  if (e_q[idx_q]) begin
                     st_q  <= S_MUL;
                     mm_go <= 1'b1;
                  end else begin
                     st_q <= S_STEP;
                  end
               end
            end
            S_MUL: begin
               if (mm_done) begin
                  acc_q <= mm_res;
                  st_q  <= S_STEP;
               end
            end
            S_STEP: begin
               mm_go <= 1'b1;
               if (idx_q == '0) begin
                  st_q <= S_FROMMONT;
               end else begin
                  idx_q <= idx_q - 1'b1;
                  st_q  <= S_SQR;
               end
            end
            S_FROMMONT: begin
               if (mm_done) begin
                  res_q  <= mm_res;
                  done_q <= 1'b1;
                  st_q   <= S_FIN;
               end
            end
            S_FIN: begin
               st_q <= S_IDLE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   assign done_o   = done_q;
   assign result_o = res_q;

endmodule

// File: rtl/mexp_engine_chk.sv
module mexp_engine_chk
   import mexp_pkg::*;
#(
   parameter int unsigned W = 16
) (
   input logic         clk_i,
   input logic         rst_ni,
   input logic         done_o,
   input logic [W-1:0] result_o,
   input logic [W-1:0] mod_q,
   input mexp_state_t  st_q,
   input logic         mm_go,
   input logic         mm_busy
);

   p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);

   p_result_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !done_o |-> $stable(result_o));

   p_result_below_mod_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o && mod_q > W'(1)) |-> (result_o < mod_q));

   p_one_product_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mm_go |-> !mm_busy);

   p_start_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q != S_IDLE) |=> $stable(mod_q));

endmodule

bind mexp_engine mexp_engine_chk #(.W(W)) chk_i (
   .clk_i    (clk_i),
   .rst_ni   (rst_ni),
   .done_o   (done_o),
   .result_o (result_o),
   .mod_q    (mod_q),
   .st_q     (st_q),
   .mm_go    (mm_go),
   .mm_busy  (mm_busy)
);

// File: tb/mexp_engine_tb_top.sv
`timescale 1ns/1ps
module mexp_engine_tb_top;

   localparam int unsigned W = 16;
   localparam int unsigned K = 4;
   localparam int unsigned E = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic [W-1:0] base_a = '0;
   logic [W-1:0] base_b = '0;
   logic [E-1:0] expo = '0;
   logic [W-1:0] modn = '0;
   logic [K-1:0] np = '0;
   logic [W-1:0] r2 = '0;
   logic         done_a, done_b;
   logic [W-1:0] res_a, res_b;

   int vectors = 0;
   int miscompares = 0;

   always #2 clk = ~clk;

   mexp_engine #(.W(W), .DIGIT_W(K), .EXP_W(E), .CONV_BASE(1'b1)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base_a),
      .exp_i(expo), .mod_i(modn), .nprime_i(np), .r2_i(r2),
      .done_o(done_a), .result_o(res_a));

   mexp_engine #(.W(W), .DIGIT_W(K), .EXP_W(E), .CONV_BASE(1'b0)) dut_pre_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base_b),
      .exp_i(expo), .mod_i(modn), .nprime_i(np), .r2_i(r2),
      .done_o(done_b), .result_o(res_b));

   function automatic longint unsigned ref_pow(longint unsigned x, longint unsigned e,
                                                longint unsigned n);
      longint unsigned r = 1 % n;
      longint unsigned b = x % n;
      while (e != 0) begin
         if (e[0]) r = (r * b) % n;
         b = (b * b) % n;
         e = e >> 1;
      end
      return r;
   endfunction

   task automatic check(string req, longint unsigned act, longint unsigned exp_v);
      vectors++;
      if (act != exp_v) begin
         miscompares++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
      end
   endtask

   task automatic load(longint unsigned x, longint unsigned e, longint unsigned n);
      longint unsigned inv = n;
      for (int i = 0; i < 5; i++) inv = (inv * (2 - n * inv)) & 64'hFFFF;
      np     = K'((64'h10000 - inv) & 64'hF);
      r2     = W'((64'h1 << 32) % n);
      base_a = W'(x);
      base_b = W'((x << 16) % n);
      expo   = E'(e);
      modn   = W'(n);
   endtask

   task automatic run_case(string req, longint unsigned x, longint unsigned e,
                           longint unsigned n);
      longint unsigned want = ref_pow(x, e, n);
      bit seen_a = 0, seen_b = 0;
      logic [W-1:0] got_a = '0, got_b = '0;
      int extra_a = 0;
      repeat (4) @(negedge clk);
      load(x, e, n);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 2000 && !(seen_a && seen_b); c++) begin
         @(negedge clk);
         if (done_a) begin
            if (seen_a) extra_a++;
            seen_a = 1; got_a = res_a;
         end
         if (done_b && !seen_b) begin seen_b = 1; got_b = res_b; end
      end
      check({req, " done seen"}, seen_a && seen_b, 1);
      check(req, got_a, want);
      check({req, " R7 preconverted"}, got_b, want);
      @(negedge clk);
      check({req, " R5 done pulse"}, done_a, 0);
      check({req, " R5 hold"}, res_a, want);
      repeat (300) @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 done_o", done_a, 0);
      check("R1 result_o", res_a, 0);
   endtask

   task automatic t_start_ignored;
      longint unsigned want = ref_pow(7, 17, 3233);
      int dones = 0;
      repeat (4) @(negedge clk);
      load(7, 17, 3233);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      load(9, 3, 211);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 2000 && dones == 0; c++) begin
         @(negedge clk);
         if (done_a) dones++;
      end
      check("R6 mid-run start, result", res_a, want);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      dones = 0;
      for (int c = 0; c < 1500; c++) begin
         @(negedge clk);
         if (done_a) dones++;
      end
      check("R6 start in done cycle, no extra done", dones, 0);
      check("R6 R5 result kept", res_a, want);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscompares++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_case("R2 e=17", 65, 17, 3233);
      run_case("R2 e=5", 1234, 5, 40961);
      run_case("R2 e=17 big n", 4321, 17, 65521);
      run_case("R3 e=0", 55, 0, 97);
      run_case("R3 e=0 n=1", 55, 0, 1);
      run_case("R4 base above n", 60000, 13, 101);
      run_case("R4 base equals n", 101, 3, 101);
      run_case("R8 full exponent", 3, 16'hFFFF, 65535);
      run_case("R8 top bit only", 12345, 16'h8000, 64999);
      run_case("R2 e=1", 777, 1, 1009);
      run_case("R9 n=3", 2, 17, 3);
      t_start_ignored();
      run_case("R2 after R6", 11, 17, 3233);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule